// File: doc/BRIEF.md
# I2C Target Address Translator

This block sits between an upstream I2C segment, where the controller lives, and a downstream segment of targets. It watches the upstream SCL and SDA lines through its own clock. After every START or repeated START it rewrites the seven address bits on the fly. Each forwarded address bit is the incoming bit XORed with the matching bit of a translation value. This lets a target with a fixed address appear at a different address upstream. The R/W bit, every ACK and all data bytes pass through unchanged.

Nothing on the downstream side is connected right after reset. The block first waits for its enable. It then captures the translation value and waits until the buses are idle. Idle means a STOP is seen upstream, or all four lines stay high for more than a set number of clock cycles. Only then does it raise the connect output for the bus switches and the READY flag. A pass-through input forces the connection on and cancels any translation at once. This allows traffic to reach the general call address. Glitches on the forwarded SDA while SCL is low are tolerated, because receivers sample only while SCL is high.

Top module: `i2c_addr_xlat`

## Requirements
- R1: The seven address bits after a START are forwarded most significant first. Forwarded bit k equals the upstream bit k XORed with bit k of the captured translation value, so address 0101 010 with value 0110 110 leaves as 0011 100.
- R2: The R/W bit, the ACK bit and every later data bit are forwarded unchanged until the next START. Wherever no translation bit is active, the output follows the synchronized upstream SDA one cycle later.
- R3: The translation mask steps STEP_DLY clock cycles after the synchronized SCL falling edge. A forwarded bit is valid from the SCL rising edge onward, and the old value still shows STEP_DLY cycles after the fall.
- R4: After reset, connect and ready are 0 and the forwarded SDA is 1. While ready is 1, connect is also 1.
- R5: With enable high, connect and ready rise only after one of two events. Either a STOP is seen upstream, or all four synchronized lines have been high for more than IDLE_CYC consecutive cycles.
- R6: The translation value is captured in the cycle enable is first seen high. Later changes on that input are ignored until enable has gone low and high again.
- R7: When enable drops, ready and connect fall within two cycles, translation stops, and the idle qualification starts over on the next enable.
- R8: Pass-through high drives connect to 1 within two cycles, whatever the state of enable or the bus. It also cancels an address translation already under way, and the remaining bits pass unmodified.
- R9: A STOP inside the address bits returns the translator to waiting, so later bits without a START pass unmodified. A START inside the address bits restarts translation from the first address bit.
- R10: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Both are judged on the synchronized lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables qualification and translation |
| passthru | input | 1 | Forces connection on, disables translation |
| xlat_val | input | 7 | Address translation value, captured on enable |
| scl_up | input | 1 | Upstream SCL level (asynchronous) |
| sda_up | input | 1 | Upstream SDA level (asynchronous) |
| scl_dn | input | 1 | Downstream SCL level (asynchronous) |
| sda_dn | input | 1 | Downstream SDA level (asynchronous) |
| sda_dn_drv | output | 1 | SDA value to drive onto the downstream segment |
| connect | output | 1 | Turns the bus switches on |
| ready | output | 1 | Qualification done, translation active |

## Verification
The assertions assume the bus obeys I2C framing: SDA changes only while SCL is low, except for START and STOP. They also assume every SCL low phase is longer than STEP_DLY plus the synchronizer depth, so the mask step finishes before the next rising edge. The stimulus drives SCL half periods of 40 cycles against a STEP_DLY of 12. It moves SDA only a few cycles after SCL has fallen, and it makes START and STOP edges only with SCL held high. The enable and pass-through inputs are treated as quasi-static controls, and the bench changes them only between bits.

// File: rtl/i2c_xlat_pkg.sv
package i2c_xlat_pkg;
  localparam int ADDR_W = 7;

  typedef enum logic [1:0] {XS_IDLE, XS_ADDR, XS_DATA} xs_t;
  typedef enum logic [1:0] {QS_OFF, QS_WAIT, QS_ON} qs_t;
endpackage

// File: rtl/i2c_xlat_sync.sv
module i2c_xlat_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else if (STAGES == 1) chain <= d[i];
      else chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_xlat_cond.sv
module i2c_xlat_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic start,
  output logic stop,
  output logic scl_fall
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  // R10: edges of SDA qualified by SCL high on both samples
  assign start    = scl & scl_d & sda_d & ~sda;
  assign stop     = scl & scl_d & ~sda_d & sda;
  assign scl_fall = scl_d & ~scl;
endmodule

// File: rtl/i2c_xlat_qual.sv
module i2c_xlat_qual
  import i2c_xlat_pkg::*;
#(
  parameter int AW       = ADDR_W,
  parameter int IDLE_CYC = 15000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          passthru,
  input  logic          all_high,
  input  logic          stop,
  input  logic [AW-1:0] xv_in,
  output logic [AW-1:0] xv_q,
  output logic          connect,
  output logic          ready
);
  localparam int CW = $clog2(IDLE_CYC + 1);

  qs_t st, st_d;
  logic [CW-1:0] cnt;

  always_comb begin
    st_d = st;
    case (st)
      QS_OFF:  if (en) st_d = QS_WAIT;
      QS_WAIT: begin
        if (!en) st_d = QS_OFF;
        else if (stop || (all_high && cnt == CW'(IDLE_CYC))) st_d = QS_ON;
      end
      QS_ON:   if (!en) st_d = QS_OFF;
      default: st_d = QS_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= QS_OFF;
      cnt     <= '0;
      xv_q    <= '0;
      connect <= 1'b0;
      ready   <= 1'b0;
    end else begin
      st <= st_d;
      if (st != QS_WAIT || !all_high) cnt <= '0;
      else if (cnt != CW'(IDLE_CYC)) cnt <= cnt + CW'(1);
      if (st == QS_OFF && en) xv_q <= xv_in;
      connect <= passthru | (st_d == QS_ON);
      ready   <= (st_d == QS_ON);
    end
  end

  // R4
  ready_has_connect_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> connect);
  // R7
  en_low_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !ready);
  // R8
  passthru_connects_chk: assert property (@(posedge clk) disable iff (rst)
    passthru |=> connect);
  // R5
  ready_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(en));
endmodule

// File: rtl/i2c_xlat_shift.sv
module i2c_xlat_shift
  import i2c_xlat_pkg::*;
#(
  parameter int AW       = ADDR_W,
  parameter int STEP_DLY = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          start,
  input  logic          stop,
  input  logic          scl_fall,
  input  logic [AW-1:0] xv,
  output logic          mask_bit
);
  localparam int DW = (STEP_DLY > 1) ? $clog2(STEP_DLY) : 1;
  localparam int CW = $clog2(AW + 1);

  xs_t           st;
  logic [AW-1:0] sreg;
  logic [CW-1:0] bcnt;
  logic [DW-1:0] dcnt;
  logic          pend;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      st       <= XS_IDLE;
      sreg     <= '0;
      bcnt     <= '0;
      dcnt     <= '0;
      pend     <= 1'b0;
      mask_bit <= 1'b0;
    end else if (stop) begin
      st       <= XS_IDLE;
      pend     <= 1'b0;
      mask_bit <= 1'b0;
    end else if (start) begin
      st       <= XS_ADDR;
      sreg     <= xv;
      bcnt     <= '0;
      dcnt     <= '0;
      pend     <= 1'b0;
      mask_bit <= 1'b0;
    end else if (st == XS_ADDR) begin
      if (scl_fall) begin
        pend <= 1'b1;
        dcnt <= '0;
      end else if (pend) begin
        if (dcnt == DW'(STEP_DLY - 1)) begin
          pend <= 1'b0;
          if (bcnt == CW'(AW)) begin
            st       <= XS_DATA;
            mask_bit <= 1'b0;
          end else begin
            mask_bit <= sreg[AW-1];
            sreg     <= {sreg[AW-2:0], 1'b0};
            bcnt     <= bcnt + CW'(1);
          end
        end else begin
          dcnt <= dcnt + DW'(1);
        end
      end
    end
  end

  // R1
  mask_only_in_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mask_bit |-> st == XS_ADDR);
  // R9
  stop_cancels_chk: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!mask_bit && st == XS_IDLE));
  // R8
  inactive_no_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> !mask_bit);
  // R2
  data_no_mask_chk: assert property (@(posedge clk) disable iff (rst)
    st == XS_DATA |-> !mask_bit);
endmodule

// File: rtl/i2c_addr_xlat.sv
module i2c_addr_xlat
  import i2c_xlat_pkg::*;
#(
  parameter int IDLE_CYC    = 15000,
  parameter int STEP_DLY    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              passthru,
  input  logic [ADDR_W-1:0] xlat_val,
  input  logic              scl_up,
  input  logic              sda_up,
  input  logic              scl_dn,
  input  logic              sda_dn,
  output logic              sda_dn_drv,
  output logic              connect,
  output logic              ready
);
  logic [3:0]        lines_s;
  logic              scl_up_s, sda_up_s;
  logic              start, stop, scl_fall;
  logic [ADDR_W-1:0] xv_q;
  logic              mask_bit;

  i2c_xlat_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({scl_up, sda_up, scl_dn, sda_dn}),
    .q(lines_s)
  );

  assign scl_up_s = lines_s[3];
  assign sda_up_s = lines_s[2];

  i2c_xlat_cond u_cond (
    .clk(clk), .rst(rst), .scl(scl_up_s), .sda(sda_up_s),
    .start(start), .stop(stop), .scl_fall(scl_fall)
  );

  i2c_xlat_qual #(.AW(ADDR_W), .IDLE_CYC(IDLE_CYC)) u_qual (
    .clk(clk), .rst(rst), .en(en), .passthru(passthru),
    .all_high(&lines_s), .stop(stop), .xv_in(xlat_val),
    .xv_q(xv_q), .connect(connect), .ready(ready)
  );

  i2c_xlat_shift #(.AW(ADDR_W), .STEP_DLY(STEP_DLY)) u_shift (
    .clk(clk), .rst(rst), .active(ready & ~passthru),
    .start(start), .stop(stop), .scl_fall(scl_fall),
    .xv(xv_q), .mask_bit(mask_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) sda_dn_drv <= 1'b1;
    else     sda_dn_drv <= sda_up_s ^ mask_bit;
  end

  // R2
  plain_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !mask_bit |=> sda_dn_drv == $past(sda_up_s));
endmodule

// File: tb/i2c_addr_xlat_bench.sv
module i2c_addr_xlat_bench;
  localparam int IDLE = 300;
  localparam int STEP = 12;
  localparam int HALF = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0, passthru = 1'b0;
  logic [6:0] xlat_val = '0;
  logic       scl_up = 1'b1, sda_up = 1'b1, scl_dn = 1'b1, sda_dn = 1'b1;
  logic       sda_dn_drv, connect, ready;
  int         nchk = 0, nbad = 0;

  always #4 clk = ~clk;

  i2c_addr_xlat #(.IDLE_CYC(IDLE), .STEP_DLY(STEP), .SYNC_STAGES(2)) u_i2c_addr_xlat (
    .clk(clk), .rst(rst), .en(en), .passthru(passthru), .xlat_val(xlat_val),
    .scl_up(scl_up), .sda_up(sda_up), .scl_dn(scl_dn), .sda_dn(sda_dn),
    .sda_dn_drv(sda_dn_drv), .connect(connect), .ready(ready)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_up = 1'b1; wt(HALF);
    scl_up = 1'b1; wt(HALF);
    sda_up = 1'b0; wt(HALF);
    scl_up = 1'b0; wt(4);
  endtask

  task automatic bus_stop;
    sda_up = 1'b0; wt(HALF);
    scl_up = 1'b1; wt(HALF);
    sda_up = 1'b1; wt(HALF);
  endtask

  task automatic send_bit(input logic b, input logic e, input string req);
    sda_up = b; wt(HALF);
    scl_up = 1'b1; wt(HALF / 2);
    chk(req, int'(sda_dn_drv), int'(e));
    wt(HALF / 2);
    scl_up = 1'b0; wt(4);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic [7:0] e, input string req);
    for (int i = 7; i >= 0; i--) send_bit(d[i], e[i], req);
    send_bit(1'b1, 1'b1, "R2 ack");
  endtask

  task automatic t_reset;
    chk("R4 connect", int'(connect), 0);
    chk("R4 ready", int'(ready), 0);
    chk("R4 sda", int'(sda_dn_drv), 1);
  endtask

  task automatic t_qual_timeout;
    xlat_val = 7'h36; en = 1'b1;
    wt(IDLE / 2);
    chk("R5 early ready", int'(ready), 0);
    chk("R5 early connect", int'(connect), 0);
    wt(IDLE);
    chk("R5 timeout ready", int'(ready), 1);
    chk("R5 timeout connect", int'(connect), 1);
    xlat_val = 7'h7F;  // R6: must be ignored
  endtask

  task automatic t_translate;
    bus_start;
    // R1 R6: 0101010 ^ 0110110 = 0011100, R/W 0 unchanged
    send_byte({7'h2A, 1'b0}, {7'h2A ^ 7'h36, 1'b0}, "R1 R6 addr");
    send_byte(8'hA5, 8'hA5, "R2 data");
    bus_start;  // repeated start
    send_byte({7'h11, 1'b1}, {7'h11 ^ 7'h36, 1'b1}, "R1 repeated addr");
    send_byte(8'h3C, 8'h3C, "R2 read data");
    bus_stop;
  endtask

  task automatic t_abort;
    bus_start;
    send_bit(1'b1, 1'b1, "R9 bit6");
    send_bit(1'b1, 1'b0, "R9 bit5");
    bus_stop;
    scl_up = 1'b0; wt(4);
    send_byte(8'h5A, 8'h5A, "R9 after stop");
    bus_start;
    send_bit(1'b0, 1'b0, "R9 bit6");
    send_bit(1'b0, 1'b1, "R9 bit5");
    bus_start;  // unexpected start mid-address
    send_byte({7'h40, 1'b0}, {7'h40 ^ 7'h36, 1'b0}, "R9 restart addr");
    bus_stop;
  endtask

  task automatic t_enable;
    en = 1'b0; wt(2);
    chk("R7 ready", int'(ready), 0);
    chk("R7 connect", int'(connect), 0);
    bus_start;
    send_byte({7'h2A, 1'b0}, {7'h2A, 1'b0}, "R7 no translate");
    bus_stop;
    xlat_val = 7'h4B; en = 1'b1;
    wt(IDLE / 2);
    chk("R7 requalify", int'(ready), 0);
    scl_up = 1'b0; wt(10);
    sda_up = 1'b0; wt(10);
    scl_up = 1'b1; wt(10);
    sda_up = 1'b1; wt(8);  // R10 STOP edge
    chk("R5 R10 stop ready", int'(ready), 1);
    chk("R5 R10 stop connect", int'(connect), 1);
  endtask

  task automatic t_step_timing;
    wt(HALF);
    sda_up = 1'b0; wt(HALF);
    scl_up = 1'b0; wt(STEP);
    chk("R3 before step", int'(sda_dn_drv), 0);
    wt(6);
    chk("R3 after step", int'(sda_dn_drv), 1);
    wt(HALF);
    bus_stop;
  endtask

  task automatic t_passthru;
    bus_start;
    send_bit(1'b0, 1'b1, "R8 bit6");
    send_bit(1'b0, 1'b0, "R8 bit5");
    passthru = 1'b1; wt(2);
    chk("R8 connect", int'(connect), 1);
    for (int i = 4; i >= 0; i--) send_bit(i[0], i[0], "R8 aborted");
    send_bit(1'b0, 1'b0, "R8 rw");
    passthru = 1'b0;
    bus_stop;
    en = 1'b0; wt(4);
    chk("R7 off", int'(connect), 0);
    passthru = 1'b1; wt(2);
    chk("R8 forced connect", int'(connect), 1);
    chk("R8 ready low", int'(ready), 0);
    passthru = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    wt(5);
    rst = 1'b0;
    wt(2);
    t_reset;
    t_qual_timeout;
    t_translate;
    t_abort;
    t_enable;
    t_step_timing;
    t_passthru;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule